// File: doc/BRIEF.md
# Read-Before-Write Byte-Lane RAM

This block is a single-clock RAM with one write port and one read port. A read that hits the same word as a write in the same clock returns the contents from before that write. The storage array underneath it only needs a plain write-transparent read. A transparent read returns data that was committed at the same edge.

To get read-before-write behaviour from that array, the block holds every write in a stage of registers for one clock. The write's address, data and per-lane enables are captured at one edge and committed to the array at the next. The read path treats this held write as already committed. For the lanes it enables, the read takes the held data, and it takes array contents for the rest. As a result, a write issued in cycle t cannot be seen by a read issued in cycle t. It can be seen by any read issued from cycle t+1 onward.

Setting `READ_FIRST` to 0 removes the stage. Writes then reach the array directly, and a same-cycle collision returns the new data. Both variants run on the rising edge of one clock and have no reset.

Top module: `rf_ram`

## Requirements
- R1: All state changes on the rising edge of `clk`. Read data is registered: `rd_data` shows the word at `rd_addr` from the edge that samples `rd_en` high.
- R2: The held write enables power up at zero, so no write reaches the array before the first write that is actually issued.
- R3: With `READ_FIRST`=1, a write's address, data and lane enables are captured at the edge that samples them. They are committed to the array at the following edge.
- R4: With `READ_FIRST`=1, a read issued in the same cycle as a write to the same address returns the contents from before that write, in every lane.
- R5: A write issued in cycle t is returned by a read of that address issued in cycle t+1 or later, including the read in cycle t+1 that finds the write still held.
- R6: The word is split into lanes of `LANE_W` bits. Lane i is bits [i*LANE_W +: LANE_W] and is written only when `wr_be[i]` is 1. Lanes whose enable is 0 keep their contents, and an all-zero `wr_be` writes nothing.
- R7: While `rd_en` is 0, `rd_data` holds its last value.
- R8: The held enables use one register per lane, fanned out to that lane's bits. A write that enables some lanes merges correctly with lanes from earlier writes.
- R9: With `READ_FIRST`=0 there is no holding stage. A same-cycle collision returns the new data in the enabled lanes and the old data in the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports, rising edge |
| wr_be | input | DATA_W/LANE_W | Per-lane write enables; a write happens when any bit is 1 |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench runs a read-before-write instance and a write-first instance side by side. Each is compared on every clock against a behavioural word-array model of its own ordering.

Directed patterns come first: a full fill and readback, collisions in the same cycle and in the next cycle, partial-lane writes, all-zero enables and held reads. Because the two instances differ only in the same-cycle collision, these patterns show whether that collision returns the old or the new word. They also show whether a held write is returned on the very next read.

Random traffic then keeps both addresses within four words. This makes collisions frequent, with random lane masks, so stale lanes or a missed bypass show up as a miscompare.

// File: rtl/rf_ram.sv
module rf_ram #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int LANE_W     = 8,
  parameter bit READ_FIRST = 1'b1
) (
  input  logic                       clk,
  input  logic [DATA_W/LANE_W-1:0]   wr_be,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int NL    = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic [NL-1:0]     c_be;
  logic [DATA_W-1:0] c_mask;
  logic              armed = 1'b0;

  always_ff @(posedge clk) armed <= 1'b1;

  generate
    if (READ_FIRST) begin : g_delay
      logic [ADDR_W-1:0] q_addr;
      logic [DATA_W-1:0] q_data;
      logic [NL-1:0]     q_be = '0;
      always_ff @(posedge clk) begin
        q_addr <= wr_addr;
        q_data <= wr_data;
        q_be   <= wr_be;
      end
      assign c_addr = q_addr;
      assign c_data = q_data;
      assign c_be   = q_be;

      a_r3_capture: assert property (@(posedge clk) disable iff (!armed)
        1'b1 |=> (q_be == $past(wr_be)) &&
                 ($past(wr_be) == '0 || (q_addr == $past(wr_addr) && q_data == $past(wr_data))));
    end else begin : g_direct
      assign c_addr = wr_addr;
      assign c_data = wr_data;
      assign c_be   = wr_be;
    end

    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign c_mask[l*LANE_W +: LANE_W] = {LANE_W{c_be[l]}};
    end
  endgenerate

  wire hit = (c_be != '0) && (c_addr == rd_addr);

  always_ff @(posedge clk) begin
    for (int l = 0; l < NL; l++)
      if (c_be[l]) mem[c_addr][l*LANE_W +: LANE_W] <= c_data[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rd_en)
      rd_data <= hit ? ((c_data & c_mask) | (mem[rd_addr] & ~c_mask)) : mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!armed) a_r2_no_early_write: assert (c_be == '0 || !READ_FIRST);
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!armed)
    !rd_en |=> $stable(rd_data));

  a_r5_bypass: assert property (@(posedge clk) disable iff (!armed)
    (rd_en && hit) |=> ((rd_data ^ $past(c_data)) & $past(c_mask)) == '0);

  a_r6_lane_mask: assert property (@(posedge clk) disable iff (!armed)
    $countones(c_mask) == $countones(c_be) * LANE_W);
endmodule

// File: tb/rf_ram_bench.sv
module rf_ram_bench;
  localparam int DW = 32, AW = 6, LW = 8, NL = DW / LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [NL-1:0] wr_be = '0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_rf, rd_wf;

  rf_ram #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(LW), .READ_FIRST(1'b1)) u_rf_ram (
    .clk(clk), .wr_be(wr_be), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_rf));

  rf_ram #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(LW), .READ_FIRST(1'b0)) u_rf_ram_wf (
    .clk(clk), .wr_be(wr_be), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_wf));

  logic [DW-1:0] m_rf [DEPTH];
  logic [DW-1:0] m_wf [DEPTH];
  logic [DW-1:0] e_rf = 'x, e_wf = 'x;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NL-1:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (be[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic cmp(string tag, string who, logic [DW-1:0] act, logic [DW-1:0] exp);
    if ($isunknown(exp)) return;
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: rd_data=%h expected %h", tag, who, act, exp);
    end
  endtask

  task automatic step(string tag, logic [NL-1:0] be, logic [AW-1:0] wa, logic [DW-1:0] wd,
                      logic re, logic [AW-1:0] ra);
    wr_be = be; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    if (re) e_rf = m_rf[ra];
    m_rf[wa] = merge(m_rf[wa], wd, be);
    m_wf[wa] = merge(m_wf[wa], wd, be);
    if (re) e_wf = m_wf[ra];
    @(negedge clk);
    cmp(tag, "read-first", rd_rf, e_rf);
    cmp(tag, "write-first", rd_wf, e_wf);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_rf[i] = 'x; m_wf[i] = 'x; end
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++)
      step("R6 fill", '1, AW'(i), DW'(32'hA5000000 + i * 32'h00010203), 1'b0, '0);
    for (int i = 0; i < DEPTH; i++)
      step("R2 R1 readback", '0, '0, '0, 1'b1, AW'(i));
    step("R4 R9 same-cycle full", '1, 6'd5, 32'h11223344, 1'b1, 6'd5);
    step("R5 next-cycle", '0, '0, '0, 1'b1, 6'd5);
    step("R4 R9 same-cycle partial", 4'b0101, 6'd7, 32'hDEADBEEF, 1'b1, 6'd7);
    step("R5 R6 partial visible", '0, '0, '0, 1'b1, 6'd7);
    step("R6 zero enables", 4'b0000, 6'd9, 32'hFFFFFFFF, 1'b0, '0);
    step("R6 zero enables read", '0, '0, '0, 1'b1, 6'd9);
    step("R7 hold a", 4'b1111, 6'd9, 32'h0BADF00D, 1'b0, 6'd9);
    step("R7 hold b", '0, '0, '0, 1'b0, 6'd9);
    step("R3 R8 lane 0", 4'b0001, 6'd3, 32'h000000AA, 1'b0, '0);
    step("R3 R8 lane 3 + read", 4'b1000, 6'd3, 32'hBB000000, 1'b1, 6'd3);
    step("R3 R8 merged", 4'b0110, 6'd3, 32'h00CCDD00, 1'b1, 6'd3);
    step("R3 R8 final", '0, '0, '0, 1'b1, 6'd3);
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa = AW'($urandom_range(0, 3));
      logic [AW-1:0] ra = ($urandom_range(0, 1) == 0) ? wa : AW'($urandom_range(0, 3));
      step("R4 R5 R6 random", NL'($urandom), wa, DW'($urandom), 1'($urandom), ra);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule